// File: doc/BRIEF.md
# Flash Completion Poll Engine

This block runs on the host side of a NOR flash and decides when an embedded program or erase has finished. A start pulse loads a target address, the byte that was written and a choice between two algorithms. In data-compare mode the top status bit is compared against the written data. In toggle mode two successive status reads are compared to see whether the toggle bit is still flipping. The engine then reads the flash through a simple request/valid port until it reaches a verdict.

A raised timing-limit bit in the status does not end the poll at once. The operation may have completed on the very read that reported the limit, so the engine takes one more look: one extra read in data-compare mode, or one extra pair of reads in toggle mode. Only that last look decides pass or fail. A poll-count limit set at build time stops a device that never settles. When it is reached, the result is a fail with a separate timeout flag.

Each run ends with a one-cycle done pulse. Pass, fail and timeout stay in registers until the next accepted start. Sending the program or erase commands and the timing of the flash bus are handled elsewhere.

Top module: `fpoll_ctrl`

## Requirements
- R1: After reset, busy, done, pass, fail, timeout and mem_req are all 0.
- R2: A start pulse while idle is accepted: busy is 1 from the next cycle, and pass, fail and timeout are cleared. A start pulse while busy is ignored: the address, the mode and the outcome of the running poll are unchanged.
- R3: Each status read holds mem_req high with mem_addr equal to the start address until mem_valid is seen together with mem_req. Status bits are taken only from mem_rdata on that handshake cycle.
- R4: Data-compare mode (start_mode = 0): when the flag bit (mem_rdata bit 7) of a read equals bit 7 of start_data, the poll ends with pass.
- R5: Data-compare mode: on a mismatch with the limit bit (mem_rdata bit 5) at 0, another read is issued.
- R6: Data-compare mode: on a mismatch with the limit bit at 1, exactly one more read is made. The poll passes if bit 7 now matches and fails otherwise.
- R7: Toggle mode (start_mode = 1): the engine reads twice. If the toggle bit (mem_rdata bit 6) is equal in both reads, the poll ends with pass.
- R8: Toggle mode: when the two toggle bits differ and the limit bit of the second read is 0, a new pair of reads begins.
- R9: Toggle mode: when the two toggle bits differ and the limit bit of the second read is 1, two more reads are made. The poll passes if their toggle bits are equal and fails otherwise.
- R10: Every read counts against MAX_POLLS. When MAX_POLLS reads have been made and the algorithm needs another, the poll ends with fail and timeout both set. A poll that resolves on read MAX_POLLS is not a timeout. MAX_POLLS = 0 removes the limit.
- R11: done is high for exactly one cycle per poll, and busy is 0 in that cycle. Exactly one of pass or fail is set with done, and the verdict holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll (only accepted while idle) |
| start_mode | input | 1 | 0 = data-compare, 1 = toggle |
| start_addr | input | AW | Flash address to read status from |
| start_data | input | 8 | Byte that was programmed (bit 7 used for compare) |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | AW | Read address |
| mem_valid | input | 1 | Read data valid (completes the request) |
| mem_rdata | input | DW | Read data; bits 7, 6 and 5 are status |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle end-of-poll pulse |
| pass | output | 1 | Last poll succeeded |
| fail | output | 1 | Last poll failed |
| timeout | output | 1 | Last poll hit the read limit |

## Verification
Scripted status sequences feed each algorithm. Data-compare mode is tried with a match on the first read, with repeated mismatches carrying a clear limit bit, with a written bit 7 of 0, and with the limit bit followed by either a match or a mismatch. Together these separate the plain retry path from the single confirming read. Toggle mode is tried with a steady bit, a bit that settles after one pair, and a limit bit whose follow-up pair is either steady or still toggling. Both modes run into the read limit, and one data poll resolves on exactly the last allowed read, which separates the boundary from a timeout. A start pulse during a poll, together with the read count and the returned address, shows that the running poll was left alone.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    // Bit positions of the status flags inside a status byte
    localparam int unsigned FLAG_BIT   = 7;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned LIMIT_BIT  = 5;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } poll_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_D_POLL   = 3'd1,
        ST_D_CONFIRM= 3'd2,
        ST_T_FIRST  = 3'd3,
        ST_T_SECOND = 3'd4,
        ST_T_RECHK1 = 3'd5,
        ST_T_RECHK2 = 3'd6
    } poll_state_e;

    typedef struct packed {
        logic flag;
        logic toggle;
        logic limit;
    } status_t;

    typedef struct packed {
        logic pass;
        logic fail;
        logic timeout;
    } verdict_t;

    function automatic status_t decode_status(input logic [7:0] b);
        status_t s;
        s.flag   = b[FLAG_BIT];
        s.toggle = b[TOGGLE_BIT];
        s.limit  = b[LIMIT_BIT];
        return s;
    endfunction

endpackage

// File: rtl/fpoll_rd_port.sv
module fpoll_rd_port
    import fpoll_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          rd_ok,
    output status_t       rd_status
);

    logic unused_rdata;
    assign unused_rdata = ^mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            rd_ok     <= 1'b0;
            rd_status <= '0;
        end else begin
            rd_ok <= 1'b0;
            if (go) begin
                mem_req <= 1'b1;
            end else if (mem_req && mem_valid) begin
                mem_req   <= 1'b0;
                rd_ok     <= 1'b1;
                rd_status <= decode_status(mem_rdata[7:0]);
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> mem_req) else $error("request dropped early"); // R3
    AST_NO_GO_PENDING: assert property (@(posedge clk) disable iff (rst)
        go |-> !mem_req) else $error("new read while one pending"); // R3

endmodule

// File: rtl/fpoll_limit.sv
module fpoll_limit #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic exhausted
);

    localparam int CW = (MAX_POLLS < 1) ? 1 : $clog2(MAX_POLLS + 1);

    generate
        if (MAX_POLLS == 0) begin : g_unlimited
            logic unused_in;
            assign unused_in = clk ^ rst ^ clear ^ tick;
            assign exhausted = 1'b0;
        end else begin : g_limited
            localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt <= '0;
                end else if (tick && cnt != LIMIT) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign exhausted = (cnt == LIMIT);

            AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
                cnt <= LIMIT) else $error("poll counter overran"); // R10
            AST_NO_READ_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
                (tick && !clear) |-> !exhausted) else $error("read past limit"); // R10
        end
    endgenerate

endmodule

// File: rtl/fpoll_seq.sv
module fpoll_seq
    import fpoll_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_mode,
    input  logic [AW-1:0] start_addr,
    input  logic          start_flag,
    input  logic          rd_ok,
    input  status_t       rd_status,
    input  logic          exhausted,
    output logic          go,
    output logic          clear,
    output logic [AW-1:0] addr,
    output logic          busy,
    output logic          done,
    output verdict_t      verdict
);

    poll_state_e state, state_n;
    logic        exp_flag;
    logic        prev_toggle;

    logic        go_n;
    logic        fin;
    logic        fin_pass;
    logic        fin_to;
    logic        cap_toggle;
    logic        want_rd;
    poll_state_e want_st;

    assign clear = start && (state == ST_IDLE);
    assign busy  = (state != ST_IDLE);

    always_comb begin
        state_n    = state;
        go_n       = 1'b0;
        fin        = 1'b0;
        fin_pass   = 1'b0;
        fin_to     = 1'b0;
        cap_toggle = 1'b0;
        want_rd    = 1'b0;
        want_st    = ST_IDLE;

        case (state)
            ST_IDLE: begin
                if (start) begin
                    go_n    = 1'b1;
                    state_n = (poll_mode_e'(start_mode) == MODE_TOGGLE) ? ST_T_FIRST : ST_D_POLL;
                end
            end
            ST_D_POLL: begin
                if (rd_ok) begin
                    if (rd_status.flag == exp_flag) begin
                        fin      = 1'b1;
                        fin_pass = 1'b1;
                    end else begin
                        want_rd = 1'b1;
                        want_st = rd_status.limit ? ST_D_CONFIRM : ST_D_POLL;
                    end
                end
            end
            ST_D_CONFIRM: begin
                if (rd_ok) begin
                    fin      = 1'b1;
                    fin_pass = (rd_status.flag == exp_flag);
                end
            end
            ST_T_FIRST, ST_T_RECHK1: begin
                if (rd_ok) begin
                    cap_toggle = 1'b1;
                    want_rd    = 1'b1;
                    want_st    = (state == ST_T_FIRST) ? ST_T_SECOND : ST_T_RECHK2;
                end
            end
            ST_T_SECOND: begin
                if (rd_ok) begin
                    if (rd_status.toggle == prev_toggle) begin
                        fin      = 1'b1;
                        fin_pass = 1'b1;
                    end else begin
                        want_rd = 1'b1;
                        want_st = rd_status.limit ? ST_T_RECHK1 : ST_T_FIRST;
                    end
                end
            end
            ST_T_RECHK2: begin
                if (rd_ok) begin
                    fin      = 1'b1;
                    fin_pass = (rd_status.toggle == prev_toggle);
                end
            end
            default: state_n = ST_IDLE;
        endcase

        if (want_rd) begin
            if (exhausted) begin
                fin      = 1'b1;
                fin_pass = 1'b0;
                fin_to   = 1'b1;
            end else begin
                go_n    = 1'b1;
                state_n = want_st;
            end
        end
        if (fin) begin
            state_n = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            go          <= 1'b0;
            done        <= 1'b0;
            verdict     <= '0;
            addr        <= '0;
            exp_flag    <= 1'b0;
            prev_toggle <= 1'b0;
        end else begin
            state <= state_n;
            go    <= go_n;
            done  <= fin;
            if (clear) begin
                addr     <= start_addr;
                exp_flag <= start_flag;
                verdict  <= '0;
            end
            if (cap_toggle) begin
                prev_toggle <= rd_status.toggle;
            end
            if (fin) begin
                verdict.pass    <= fin_pass;
                verdict.fail    <= !fin_pass;
                verdict.timeout <= fin_to;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("busy during done"); // R11
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        done |-> (verdict.pass ^ verdict.fail)) else $error("verdict not exclusive"); // R11
    AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (rst)
        verdict.timeout |-> verdict.fail) else $error("timeout without fail"); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(addr)) else $error("address moved mid-poll"); // R2
    AST_CONFIRM_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_D_CONFIRM && rd_ok) |=> !busy) else $error("extra read after confirm"); // R6

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
    import fpoll_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DW        = 8,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_mode,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          timeout
);

    logic     go;
    logic     clear;
    logic     rd_ok;
    status_t  rd_status;
    logic     exhausted;
    verdict_t verdict;

    logic unused_data_low;
    assign unused_data_low = ^start_data[6:0];

    fpoll_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_mode (start_mode),
        .start_addr (start_addr),
        .start_flag (start_data[FLAG_BIT]),
        .rd_ok      (rd_ok),
        .rd_status  (rd_status),
        .exhausted  (exhausted),
        .go         (go),
        .clear      (clear),
        .addr       (mem_addr),
        .busy       (busy),
        .done       (done),
        .verdict    (verdict)
    );

    fpoll_rd_port #(.DW(DW)) u_port (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .rd_ok     (rd_ok),
        .rd_status (rd_status)
    );

    fpoll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .tick      (go),
        .exhausted (exhausted)
    );

    assign pass    = verdict.pass;
    assign fail    = verdict.fail;
    assign timeout = verdict.timeout;

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !mem_req) else $error("request while idle"); // R3

endmodule

// File: tb/tb_fpoll_ctrl.sv
`timescale 1ns/1ps
module tb_fpoll_ctrl;

    localparam int AW  = 24;
    localparam int DW  = 8;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          start_mode = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, pass, fail, timeout;

    int errors = 0;
    int checks = 0;
    int nreads = 0;
    int base   = 0;
    int slen   = 1;
    logic [7:0] script [0:15];
    bit finished = 0;

    always #2.5 clk = ~clk;

    fpoll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(LIM)) dut (
        .clk(clk), .rst(rst), .start(start), .start_mode(start_mode),
        .start_addr(start_addr), .start_data(start_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .timeout(timeout)
    );

    // Flash model: answers each request one cycle later from the script
    always @(posedge clk) begin
        if (mem_req && mem_valid) nreads <= nreads + 1;
        mem_valid <= mem_req && !mem_valid;
        mem_rdata <= script[(nreads - base) % slen];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3);
        script[0] = b0; script[1] = b1; script[2] = b2; script[3] = b3;
        slen = n;
    endtask

    task automatic kick(input logic mode, input logic [7:0] expb, input logic [AW-1:0] a);
        @(negedge clk);
        base       = nreads;
        start      = 1'b1;
        start_mode = mode;
        start_data = expb;
        start_addr = a;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        check({pass, fail, timeout} === 3'b000, "R2 verdict cleared", int'({pass, fail, timeout}), 0);
    endtask

    task automatic finish_poll(input string req, input bit exp_pass, input bit exp_to,
                               input int exp_reads, input logic [AW-1:0] a);
        int n = 0;
        while (done !== 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, {req, " done seen"}, int'(done), 1);
        check(pass === exp_pass && fail === !exp_pass, {req, " pass/fail"}, int'({pass, fail}), int'({exp_pass, !exp_pass}));
        check(timeout === exp_to, {req, " timeout"}, int'(timeout), int'(exp_to));
        check(nreads - base == exp_reads, {req, " read count"}, nreads - base, exp_reads);
        check(mem_addr === a, "R3 address", int'(mem_addr), int'(a));
        check(busy === 1'b0, "R11 busy low at done", int'(busy), 0);
        @(negedge clk);
        check(done === 1'b0, "R11 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check(pass === exp_pass && timeout === exp_to, "R11 verdict held", int'({pass, timeout}), int'({exp_pass, exp_to}));
    endtask

    task automatic t_reset();
        check({busy, done, pass, fail, timeout, mem_req} === 6'b0, "R1 reset outputs",
              int'({busy, done, pass, fail, timeout, mem_req}), 0);
    endtask

    task automatic t_data_first();
        load(1, 8'h80, 8'h00, 8'h00, 8'h00);
        kick(1'b0, 8'h80, 24'h001000);
        finish_poll("R4 data first match", 1'b1, 1'b0, 1, 24'h001000);
    endtask

    task automatic t_data_retry();
        load(3, 8'h00, 8'h00, 8'h80, 8'h80);
        kick(1'b0, 8'hA5, 24'h002000);
        finish_poll("R5 data retry", 1'b1, 1'b0, 3, 24'h002000);
    endtask

    task automatic t_data_zero();
        load(2, 8'h80, 8'h00, 8'h00, 8'h00);
        kick(1'b0, 8'h3C, 24'h002100);
        finish_poll("R4 data bit7 zero", 1'b1, 1'b0, 2, 24'h002100);
    endtask

    task automatic t_data_limit_pass();
        load(2, 8'h20, 8'h80, 8'h80, 8'h80);
        kick(1'b0, 8'h80, 24'h003000);
        finish_poll("R6 limit bit then match", 1'b1, 1'b0, 2, 24'h003000);
    endtask

    task automatic t_data_limit_fail();
        load(3, 8'h20, 8'h20, 8'h80, 8'h80);
        kick(1'b0, 8'h80, 24'h004000);
        finish_poll("R6 limit bit then mismatch", 1'b0, 1'b0, 2, 24'h004000);
    endtask

    task automatic t_tog_steady();
        load(2, 8'h00, 8'h00, 8'h40, 8'h40);
        kick(1'b1, 8'h00, 24'h005000);
        finish_poll("R7 toggle steady", 1'b1, 1'b0, 2, 24'h005000);
    endtask

    task automatic t_tog_settle();
        load(4, 8'h00, 8'h40, 8'h40, 8'h40);
        kick(1'b1, 8'h00, 24'h006000);
        finish_poll("R8 toggle settles", 1'b1, 1'b0, 4, 24'h006000);
    endtask

    task automatic t_tog_limit_pass();
        load(4, 8'h00, 8'h60, 8'h60, 8'h60);
        kick(1'b1, 8'h00, 24'h007000);
        finish_poll("R9 limit bit then steady", 1'b1, 1'b0, 4, 24'h007000);
    endtask

    task automatic t_tog_limit_fail();
        load(4, 8'h00, 8'h60, 8'h20, 8'h60);
        kick(1'b1, 8'h00, 24'h008000);
        finish_poll("R9 limit bit still toggling", 1'b0, 1'b0, 4, 24'h008000);
    endtask

    task automatic t_timeout_data();
        load(1, 8'h00, 8'h00, 8'h00, 8'h00);
        kick(1'b0, 8'h80, 24'h009000);
        finish_poll("R10 data timeout", 1'b0, 1'b1, LIM, 24'h009000);
    endtask

    task automatic t_timeout_tog();
        load(2, 8'h00, 8'h40, 8'h00, 8'h40);
        kick(1'b1, 8'h00, 24'h00A000);
        finish_poll("R10 toggle timeout", 1'b0, 1'b1, LIM, 24'h00A000);
    endtask

    task automatic t_last_read();
        for (int i = 0; i < LIM - 1; i++) script[i] = 8'h00;
        script[LIM - 1] = 8'h80;
        slen = LIM;
        kick(1'b0, 8'h80, 24'h00B000);
        finish_poll("R10 resolves on last read", 1'b1, 1'b0, LIM, 24'h00B000);
    endtask

    task automatic t_start_ignored();
        load(4, 8'h00, 8'h00, 8'h00, 8'h80);
        kick(1'b0, 8'h80, 24'h00C000);
        repeat (3) @(negedge clk);
        start      = 1'b1;
        start_mode = 1'b1;
        start_data = 8'h00;
        start_addr = 24'h0FFFFF;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 still busy after ignored start", int'(busy), 1);
        check(mem_addr === 24'h00C000, "R2 address kept", int'(mem_addr), 24'h00C000);
        finish_poll("R2 ignored start", 1'b1, 1'b0, 4, 24'h00C000);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) script[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data_first();
        t_data_retry();
        t_data_zero();
        t_data_limit_pass();
        t_data_limit_fail();
        t_tog_steady();
        t_tog_settle();
        t_tog_limit_pass();
        t_tog_limit_fail();
        t_timeout_data();
        t_timeout_tog();
        t_last_read();
        t_start_ignored();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule